// File: doc/BRIEF.md
# Memory Self-Test Sequencer

This block exercises an external memory through a simple request/acknowledge bus that sits in front of a memory controller. It does nothing after reset until the controller reports that calibration is complete. It then makes three passes over every address of the memory. The first pass writes all addresses in ascending order and afterwards reads them all back. The second pass does the same in a pseudo-random order that reaches every address once. The third pass walks the addresses in ascending order and reads each one back straight after writing it.

Write data is a function of the address and of the current pass, so the expected value of every read is computed again at compare time and nothing has to be stored. The first wrong read word sets a sticky fail flag and records its address. The test still runs to the end and then raises done. A set of status LEDs lights only when the test has finished without error and calibration is still reported.

Top module: `mbist_engine`

## Requirements
- R1: After reset `bus_stb_o`, `done_o`, `fail_o` and `led_o` are all low. No request is issued while `cal_done_i` has never been seen high. Once it is high, the first request appears within a few cycles.
- R2: Only one access is outstanding at a time. While `bus_stb_o` is high and `bus_ack_i` is low, the address, direction and write data stay unchanged. One acknowledge completes exactly one access.
- R3: Every write carries the address, zero-extended to DW bits, XORed with a pass key. The key is the nibble 0x5 repeated for the burst pass, 0xA repeated for the random pass and 0x3 repeated for the alternating pass. `bus_we_o` high means write.
- R4: The burst pass writes addresses 0 to N-1 in ascending order, where N is 2^AW. It then reads addresses 0 to N-1 in ascending order.
- R5: The random pass makes N writes. They start at address 0, reach every address exactly once, and do not follow ascending order. The pass then makes N reads in exactly the same address order.
- R6: The alternating pass visits addresses 0 to N-1 in ascending order. At each address it issues a write and then, as the very next access, a read of that same address.
- R7: The passes run in the order burst, random, alternating, for 6*N accesses in total. `done_o` then rises and stays high, and no further request is issued.
- R8: Every read word is compared with the value written there. The first mismatch sets `fail_o` and stores its address in `fail_addr_o`. Later mismatches change neither output, and the test still completes.
- R9: `led_o` is all ones exactly when `done_o` is high, `fail_o` is low and `cal_done_i` is high. In every other case it is all zeros.
- R10: Correct operation does not depend on acknowledge latency. This includes an acknowledge in the cycle right after the request is seen, and latencies that vary from one access to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cal_done_i | input | 1 | Memory controller calibration complete |
| bus_stb_o | output | 1 | Access request, held until acknowledged |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_adr_o | output | AW | Word address of the access |
| bus_dat_o | output | DW | Write data |
| bus_dat_i | input | DW | Read data, valid with acknowledge |
| bus_ack_i | input | 1 | Access complete |
| done_o | output | 1 | All passes finished |
| fail_o | output | 1 | Sticky: a read mismatch occurred |
| fail_addr_o | output | AW | Address of the first mismatch |
| led_o | output | LEDS | Status lights, all on when the test finished clean |

## Verification
The bench builds the block with AW=6 and DW=12. With 64 addresses, a full run of 384 accesses is short, so six complete runs fit easily, even at the longest acknowledge latency. A 6-bit address selects a maximal-length feedback pattern with only two taps. The 12-bit data path places each pass key across three nibbles above the address bits, so a key applied to the wrong pass or a truncated key shows up in the data check. The small address space also lets the bench count exactly one random-pass write per address and place injected read faults in a chosen pass.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  typedef enum logic [1:0] {ST_WAIT, ST_RUN, ST_DONE} run_state_e;

  typedef enum logic [1:0] {PH_BURST, PH_RAND, PH_ALT} phase_e;

  // Feedback mask for a left-shifting maximal-length register, bit k = stage k
  function automatic logic [31:0] lfsr_taps(input int width);
    case (width)
      3:       lfsr_taps = 32'h0000_0006;
      4:       lfsr_taps = 32'h0000_000C;
      5:       lfsr_taps = 32'h0000_0014;
      6:       lfsr_taps = 32'h0000_0030;
      7:       lfsr_taps = 32'h0000_0060;
      8:       lfsr_taps = 32'h0000_00B8;
      9:       lfsr_taps = 32'h0000_0110;
      10:      lfsr_taps = 32'h0000_0240;
      11:      lfsr_taps = 32'h0000_0500;
      12:      lfsr_taps = 32'h0000_0829;
      13:      lfsr_taps = 32'h0000_100D;
      14:      lfsr_taps = 32'h0000_2015;
      15:      lfsr_taps = 32'h0000_6000;
      16:      lfsr_taps = 32'h0000_D008;
      default: lfsr_taps = 32'h0000_0006;
    endcase
  endfunction

  function automatic logic [3:0] key_nibble(input phase_e ph);
    case (ph)
      PH_BURST: key_nibble = 4'h5;
      PH_RAND:  key_nibble = 4'hA;
      default:  key_nibble = 4'h3;
    endcase
  endfunction

endpackage

// File: rtl/mbist_addr_gen.sv
module mbist_addr_gen #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart_i,
  input  logic          step_i,
  input  logic          rand_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);

  localparam logic [31:0]   TAP_ALL = mbist_pkg::lfsr_taps(AW);
  localparam logic [AW-1:0] TAPS    = TAP_ALL[AW-1:0];
  localparam logic [AW-1:0] SEED    = AW'(1);

  logic [AW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] lfsr_q, lfsr_d, lfsr_nxt;
  logic          upd_en;

  always_comb lfsr_nxt = {lfsr_q[AW-2:0], ^(lfsr_q & TAPS)};

  // Step 0 of a pass is address 0; steps 1..N-1 walk the nonzero LFSR states
  always_comb begin
    upd_en = restart_i | step_i;
    cnt_d  = cnt_q;
    lfsr_d = lfsr_q;
    if (restart_i) begin
      cnt_d  = '0;
      lfsr_d = SEED;
    end else if (step_i) begin
      cnt_d = cnt_q + AW'(1);
      if (cnt_q != '0) lfsr_d = lfsr_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lfsr_q <= SEED;
    end else if (upd_en) begin
      cnt_q  <= cnt_d;
      lfsr_q <= lfsr_d;
    end
  end

  assign addr_o = (rand_i && cnt_q != '0) ? lfsr_q : cnt_q;
  assign last_o = &cnt_q;

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0); // R5

endmodule

// File: rtl/mbist_pattern.sv
module mbist_pattern #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  mbist_pkg::phase_e phase_i,
  input  logic [AW-1:0]     addr_i,
  output logic [DW-1:0]     data_o
);

  localparam int NIBS = DW / 4;

  logic [3:0]    nib;
  logic [DW-1:0] key;

  always_comb begin
    nib = mbist_pkg::key_nibble(phase_i);
    key = '0;
    for (int i = 0; i < NIBS; i++) key[4*i +: 4] = nib;
    data_o = DW'(addr_i) ^ key;
  end

endmodule

// File: rtl/mbist_engine.sv
module mbist_engine #(
  parameter int AW   = 8,
  parameter int DW   = 16,
  parameter int LEDS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cal_done_i,
  output logic            bus_stb_o,
  output logic            bus_we_o,
  output logic [AW-1:0]   bus_adr_o,
  output logic [DW-1:0]   bus_dat_o,
  input  logic [DW-1:0]   bus_dat_i,
  input  logic            bus_ack_i,
  output logic            done_o,
  output logic            fail_o,
  output logic [AW-1:0]   fail_addr_o,
  output logic [LEDS-1:0] led_o
);

  import mbist_pkg::*;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  run_state_e    state_q, state_d;
  phase_e        phase_q, phase_d;
  logic          rd_q, rd_d;
  logic          fail_q, fail_d;
  logic [AW-1:0] fail_addr_q, fail_addr_d;
  logic          fail_en;

  logic          ag_restart, ag_step, ag_last;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] exp_data;

  mbist_addr_gen #(.AW(AW)) u_addr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .restart_i (ag_restart),
    .step_i    (ag_step),
    .rand_i    (phase_q == PH_RAND),
    .addr_o    (cur_addr),
    .last_o    (ag_last)
  );

  mbist_pattern #(.AW(AW), .DW(DW)) u_pat (
    .phase_i (phase_q),
    .addr_i  (cur_addr),
    .data_o  (exp_data)
  );

  always_comb begin
    state_d     = state_q;
    phase_d     = phase_q;
    rd_d        = rd_q;
    fail_d      = fail_q;
    fail_addr_d = fail_addr_q;
    fail_en     = 1'b0;
    ag_restart  = 1'b0;
    ag_step     = 1'b0;
    case (state_q)
      ST_WAIT: begin
        if (cal_done_i) begin
          state_d    = ST_RUN;
          phase_d    = PH_BURST;
          rd_d       = 1'b0;
          ag_restart = 1'b1;
        end
      end
      ST_RUN: begin
        if (bus_ack_i) begin
          if (rd_q && (bus_dat_i != exp_data) && !fail_q) begin
            fail_en     = 1'b1;
            fail_d      = 1'b1;
            fail_addr_d = cur_addr;
          end
          if (phase_q == PH_ALT) begin
            if (!rd_q) begin
              rd_d = 1'b1;
            end else begin
              rd_d = 1'b0;
              if (ag_last) state_d = ST_DONE;
              else         ag_step = 1'b1;
            end
          end else if (!ag_last) begin
            ag_step = 1'b1;
          end else if (!rd_q) begin
            rd_d       = 1'b1;
            ag_restart = 1'b1;
          end else begin
            rd_d       = 1'b0;
            ag_restart = 1'b1;
            phase_d    = (phase_q == PH_BURST) ? PH_RAND : PH_ALT;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_WAIT;
      phase_q <= PH_BURST;
      rd_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      rd_q    <= rd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      fail_q      <= 1'b0;
      fail_addr_q <= '0;
    end else if (fail_en) begin
      fail_q      <= fail_d;
      fail_addr_q <= fail_addr_d;
    end
  end

  assign bus_stb_o   = (state_q == ST_RUN);
  assign bus_we_o    = ~rd_q;
  assign bus_adr_o   = cur_addr;
  assign bus_dat_o   = exp_data;
  assign done_o      = (state_q == ST_DONE);
  assign fail_o      = fail_q;
  assign fail_addr_o = fail_addr_q;
  assign led_o       = {LEDS{done_o & ~fail_q & cal_done_i}};

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_stb_o && !bus_ack_i) |=> (bus_stb_o && $stable(bus_adr_o) && $stable(bus_we_o) && $stable(bus_dat_o))); // R2

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |=> (done_o && !bus_stb_o)); // R7

  AST_FAIL_FROZEN: assert property (@(posedge clk) disable iff (!rst_int_n)
    fail_o |=> (fail_o && $stable(fail_addr_o))); // R8

  AST_ALT_READBACK: assert property (@(posedge clk) disable iff (!rst_int_n)
    (phase_q == PH_ALT && bus_stb_o && bus_ack_i && bus_we_o) |=> (bus_stb_o && !bus_we_o && $stable(bus_adr_o))); // R6

endmodule

// File: tb/sim_mbist_engine.sv
module sim_mbist_engine;

  localparam int AW = 6;
  localparam int DW = 12;
  localparam int LEDS = 4;
  localparam int N = 1 << AW;
  localparam int CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cal_done;
  logic            stb, we, ack;
  logic [AW-1:0]   adr, fail_addr;
  logic [DW-1:0]   wdat, rdata;
  logic            done, fail;
  logic [LEDS-1:0] led;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbist_engine #(.AW(AW), .DW(DW), .LEDS(LEDS)) u0 (
    .clk (clk), .rst_n (rst_n), .cal_done_i (cal_done),
    .bus_stb_o (stb), .bus_we_o (we), .bus_adr_o (adr), .bus_dat_o (wdat),
    .bus_dat_i (rdata), .bus_ack_i (ack),
    .done_o (done), .fail_o (fail), .fail_addr_o (fail_addr), .led_o (led)
  );

  int checks = 0;
  int errors = 0;

  // behavioural memory and transaction monitor state
  logic [DW-1:0] mem [N];
  int order [N];
  int wcnt [N];
  int txn, lat_mode, lat_now, wait_cnt;
  int hold_err, data_err, ord_b, ord_r, ord_a, extra_err;
  bit busy;
  logic [AW-1:0] cap_adr;
  logic          cap_we;
  logic [DW-1:0] cap_dat;
  bit f_en [2];
  int f_adr [2];
  int f_seg [2];

  function automatic logic [DW-1:0] key_of(input int ph);
    logic [3:0] nib;
    logic [DW-1:0] k;
    nib = (ph == 0) ? 4'h5 : (ph == 1) ? 4'hA : 4'h3;
    k = '0;
    for (int i = 0; i < DW/4; i++) k[4*i +: 4] = nib;
    return k;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack   <= 1'b0;
      rdata <= '0;
      busy = 1'b0;
      wait_cnt = 0;
    end else begin
      ack <= 1'b0;
      if (stb && !ack) begin
        if (!busy) begin
          busy = 1'b1;
          cap_adr = adr; cap_we = we; cap_dat = wdat;
          wait_cnt = 0;
          lat_now = (lat_mode == 0) ? 0 : (lat_mode == 2) ? 3 : (txn * 7 + 3) % 6;
        end else if (adr != cap_adr || we != cap_we || (we && wdat != cap_dat)) begin
          hold_err++;
        end
        if (wait_cnt >= lat_now) begin
          int seg, j, jj;
          logic [DW-1:0] flip;
          ack <= 1'b1;
          busy = 1'b0;
          seg = txn / N;
          j = txn % N;
          if (txn >= 6*N) extra_err++;
          else begin
            case (seg)
              0: if (!we || int'(adr) != j) ord_b++;
              1: if (we || int'(adr) != j) ord_b++;
              2: if (!we) ord_r++; else begin order[j] = int'(adr); wcnt[adr]++; end
              3: if (we || int'(adr) != order[j]) ord_r++;
              default: begin
                jj = txn - 4*N;
                if (we != ((jj % 2) == 0) || int'(adr) != jj / 2) ord_a++;
              end
            endcase
            if (we && wdat != (DW'(adr) ^ key_of(seg / 2))) data_err++;
          end
          if (we) mem[adr] = wdat;
          else begin
            flip = '0;
            for (int f = 0; f < 2; f++)
              if (f_en[f] && int'(adr) == f_adr[f] && seg == f_seg[f]) flip = DW'(1);
            rdata <= mem[adr] ^ flip;
          end
          txn++;
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int mode);
    rst_n = 1'b0;
    cal_done = 1'b0;
    lat_mode = mode;
    txn = 0; hold_err = 0; data_err = 0; ord_b = 0; ord_r = 0; ord_a = 0; extra_err = 0;
    for (int i = 0; i < N; i++) begin order[i] = -1; wcnt[i] = 0; mem[i] = '0; end
    for (int f = 0; f < 2; f++) begin f_en[f] = 1'b0; f_adr[f] = 0; f_seg[f] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_and_check(input string name, input bit exp_fail, input int exp_addr);
    int bad_cov, ident;
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    check(done === 1'b1, {"R7 done reached ", name}, int'(done), 1);
    repeat (3) @(negedge clk);
    check(stb === 1'b0, "R7 no request after done", int'(stb), 0);
    check(txn == 6*N, "R7 access count", txn, 6*N);
    check(extra_err == 0, "R7 extra accesses", extra_err, 0);
    check(ord_b == 0, "R4 burst order", ord_b, 0);
    check(ord_r == 0, "R5 random order/readback", ord_r, 0);
    bad_cov = 0; ident = 0;
    for (int i = 0; i < N; i++) begin
      if (wcnt[i] != 1) bad_cov++;
      if (order[i] == i) ident++;
    end
    check(bad_cov == 0, "R5 each address once", bad_cov, 0);
    check(order[0] == 0 && ident < N, "R5 starts at 0, not ascending", ident, N);
    check(ord_a == 0, "R6 alternating order", ord_a, 0);
    check(data_err == 0, "R3 write data pattern", data_err, 0);
    check(hold_err == 0, "R2 request held until ack", hold_err, 0);
    check(fail === exp_fail, {"R8 fail flag ", name}, int'(fail), int'(exp_fail));
    if (exp_fail) check(int'(fail_addr) == exp_addr, "R8 first fail address", int'(fail_addr), exp_addr);
    check(led == (exp_fail ? '0 : '1), "R9 leds", int'(led), exp_fail ? 0 : 15);
  endtask

  task automatic t_cal_gate_clean;
    int seen;
    do_reset(0);
    check(stb === 1'b0 && done === 1'b0 && fail === 1'b0 && led === '0, "R1 reset state", int'({stb, done, fail}), 0);
    seen = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (stb) seen++; end
    check(seen == 0, "R1 no request before calibration", seen, 0);
    cal_done = 1'b1;
    repeat (2) @(negedge clk);
    check(stb === 1'b1, "R1 request after calibration", int'(stb), 1);
    run_and_check("clean, latency 0 (R10)", 1'b0, 0);
    cal_done = 1'b0;
    #1;
    check(led === '0, "R9 leds off when calibration drops", int'(led), 0);
  endtask

  task automatic t_var_latency;
    do_reset(1);
    cal_done = 1'b1;
    run_and_check("clean, varying latency (R10)", 1'b0, 0);
  endtask

  task automatic t_burst_fault;
    do_reset(2);
    f_en[0] = 1'b1; f_adr[0] = 'h2A; f_seg[0] = 1;
    cal_done = 1'b1;
    run_and_check("burst read fault", 1'b1, 'h2A);
  endtask

  task automatic t_rand_fault;
    do_reset(1);
    f_en[0] = 1'b1; f_adr[0] = 'h05; f_seg[0] = 3;
    cal_done = 1'b1;
    run_and_check("random read fault (R5)", 1'b1, 'h05);
  endtask

  task automatic t_alt_fault;
    do_reset(0);
    f_en[0] = 1'b1; f_adr[0] = 'h30; f_seg[0] = 5;
    cal_done = 1'b1;
    run_and_check("alternating read fault (R6)", 1'b1, 'h30);
  endtask

  task automatic t_sticky;
    do_reset(2);
    f_en[0] = 1'b1; f_adr[0] = 'h3C; f_seg[0] = 1;
    f_en[1] = 1'b1; f_adr[1] = 'h01; f_seg[1] = 3;
    cal_done = 1'b1;
    run_and_check("two faults, first kept (R8)", 1'b1, 'h3C);
  endtask

  initial begin
    t_cal_gate_clean();
    t_var_latency();
    t_burst_fault();
    t_rand_fault();
    t_alt_fault();
    t_sticky();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule